// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. A processor requests a conversion with a one-clock start pulse. The block then drives a trial code to an external DAC. It reads back a single comparator bit that says whether the analog input is at or above the DAC output, and it settles one bit of the result on each clock, starting with the most significant bit. The time a conversion takes is fixed and does not depend on the input value.

A single status line is low while a conversion runs and high when a valid result is held. The processor fetches the result as two bytes, using a high-byte select and a low-byte select. While the bits are being decided, the block also sends them out serially, one per clock with a valid strobe. This lets a serial consumer take the result without waiting for the end of the conversion. The DAC and the comparator sit outside the block.

Top module: `sar_ctrl`

## Requirements
- R1: After reset the status line `eoc_o` is 1, `dac_code_o` is 0, `ser_vld_o` is 0 and the read bus returns 0 for every select setting.
- R2: A start pulse sampled while `eoc_o` is 1 begins a conversion: in the next cycle `eoc_o` is 0 and `dac_code_o` holds only the most significant bit set.
- R3: On each clock of a conversion, the bit under test stays set if `cmp_ge_i` is 1 and is cleared if it is 0. The next lower bit is then set as the new trial, so the trial code rises or stays put on a 1 and falls on a 0.
- R4: `eoc_o` stays 0 for exactly W clocks after the start cycle and then returns to 1, for any input value.
- R5: At the end of a conversion the held result equals the final trial code. With an ideal comparator and a constant input, this equals the input code.
- R6: `ser_vld_o` is 1 for exactly W consecutive cycles per conversion. In each of those cycles `ser_bit_o` carries the decision just made, most significant bit first.
- R7: With `hi_sel_i` = 1, `rd_data_o` returns result bits [W-1:8], zero-extended to 8 bits. This select wins when both selects are 1.
- R8: With `lo_sel_i` = 1 and `hi_sel_i` = 0, `rd_data_o` returns result bits [7:0].
- R9: With both selects at 0, `rd_data_o` is 0.
- R10: A start pulse sampled while `eoc_o` is 0 is ignored. The running conversion keeps its trial sequence and its end time.
- R11: The held result, as seen on the read bus, does not change during a conversion. It is replaced only in the clock where `eoc_o` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request pulse |
| cmp_ge_i | input | 1 | Comparator: 1 when the analog input is at or above the DAC output |
| hi_sel_i | input | 1 | High-byte read select |
| lo_sel_i | input | 1 | Low-byte read select |
| dac_code_o | output | W | Trial code driven to the DAC |
| eoc_o | output | 1 | 0 while converting, 1 when the result is valid |
| rd_data_o | output | 8 | Selected result byte |
| ser_bit_o | output | 1 | Serial result bit, most significant first |
| ser_vld_o | output | 1 | Strobe for `ser_bit_o` |

## Verification
The bench builds the block with its default 12-bit width. The high byte therefore carries four live bits over four forced zeros, which brings the zero-extension of R7 within reach. Input codes include all zeros, all ones and the two codes on either side of mid-scale. In these cases every decision is the same, or the decisions flip only at the first bit. A start pulse is also placed in the middle of a run, and the read selects cycle through all four settings while a conversion is in progress.

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int W     = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_ge_i,
  input  logic             hi_sel_i,
  input  logic             lo_sel_i,
  output logic [W-1:0]     dac_code_o,
  output logic             eoc_o,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             ser_bit_o,
  output logic             ser_vld_o
);
  localparam int HI_W = W - BUS_W;
  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  logic         busy_q;
  logic [W-1:0] trial_q, probe_q, result_q, kept;
  logic [BUS_W-1:0] hi_view, lo_view;

  assign kept = cmp_ge_i ? trial_q : (trial_q & ~probe_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      trial_q   <= '0;
      probe_q   <= '0;
      result_q  <= '0;
      ser_bit_o <= 1'b0;
      ser_vld_o <= 1'b0;
    end else begin
      ser_vld_o <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q  <= 1'b1;
        trial_q <= TOP_BIT;
        probe_q <= TOP_BIT;
      end else if (busy_q) begin
        ser_bit_o <= cmp_ge_i;
        ser_vld_o <= 1'b1;
        trial_q   <= kept | (probe_q >> 1);
        probe_q   <= probe_q >> 1;
        if (probe_q[0]) begin
          busy_q   <= 1'b0;
          result_q <= kept;
        end
      end
    end
  end

  assign lo_view = result_q[BUS_W-1:0];

  generate
    if (HI_W < BUS_W) begin : g_pad
      assign hi_view = {{(BUS_W-HI_W){1'b0}}, result_q[W-1:BUS_W]};
    end else begin : g_full
      assign hi_view = result_q[W-1:BUS_W];
    end
  endgenerate

  assign rd_data_o  = hi_sel_i ? hi_view : (lo_sel_i ? lo_view : '0);
  assign dac_code_o = trial_q;
  assign eoc_o      = ~busy_q;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int W     = 12,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cmp_ge_i,
  input logic             hi_sel_i,
  input logic             lo_sel_i,
  input logic [W-1:0]     dac_code_o,
  input logic             eoc_o,
  input logic [BUS_W-1:0] rd_data_o,
  input logic             ser_vld_o
);
  localparam int CW = $clog2(W + 1) + 1;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_cnt <= '0;
    else if (!eoc_o) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  p_start_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_o) |-> dac_code_o == {1'b1, {(W-1){1'b0}}});

  p_keep_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && cmp_ge_i) |=> dac_code_o >= $past(dac_code_o));

  p_drop_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && !cmp_ge_i) |=> dac_code_o < $past(dac_code_o));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_o) |-> low_cnt == CW'(W));

  p_vld_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld_o |-> $past(!eoc_o));

  p_idle_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_sel_i && !lo_sel_i) |-> rd_data_o == '0);

  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && $past(!eoc_o) && $stable(hi_sel_i) && $stable(lo_sel_i))
      |-> $stable(rd_data_o));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_o && start_i && dac_code_o[W-1:1] != '0 && !dac_code_o[0]) |=> !eoc_o);
endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_ge_i(cmp_ge_i),
  .hi_sel_i(hi_sel_i), .lo_sel_i(lo_sel_i), .dac_code_o(dac_code_o),
  .eoc_o(eoc_o), .rd_data_o(rd_data_o), .ser_vld_o(ser_vld_o)
);

// File: tb/sar_ctrl_tb_top.sv
module sar_ctrl_tb_top;
  localparam int W = 12;
  localparam int B = 8;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic hi_sel_i = 1'b0, lo_sel_i = 1'b0;
  logic [W-1:0] vin = '0;
  logic cmp_ge_i;
  logic [W-1:0] dac_code_o;
  logic eoc_o, ser_bit_o, ser_vld_o;
  logic [B-1:0] rd_data_o;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  assign cmp_ge_i = (vin >= dac_code_o);

  sar_ctrl #(.W(W), .BUS_W(B)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_ge_i(cmp_ge_i),
    .hi_sel_i(hi_sel_i), .lo_sel_i(lo_sel_i), .dac_code_o(dac_code_o),
    .eoc_o(eoc_o), .rd_data_o(rd_data_o), .ser_bit_o(ser_bit_o),
    .ser_vld_o(ser_vld_o)
  );

  // behavioural reference: decision at step s equals input bit W-1-s
  bit           m_busy = 0, m_vld = 0, m_ser = 0, m_ign = 0;
  int           m_step = 0;
  logic [W-1:0] m_code = '0, m_result = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_vld <= 0; m_ser <= 0; m_step <= 0;
      m_code <= '0; m_result <= '0; m_ign <= 0;
    end else if (!m_busy) begin
      m_vld <= 0;
      m_ign <= 0;
      if (start_i) begin
        m_busy <= 1; m_step <= 0; m_code <= W'(1) << (W-1);
      end
    end else begin
      automatic int bitn = W - 1 - m_step;
      automatic logic [W-1:0] c = (vin >> bitn) << bitn;
      if (bitn > 0) c = c | (W'(1) << (bitn - 1));
      m_ser  <= vin[bitn];
      m_vld  <= 1;
      m_code <= c;
      m_step <= m_step + 1;
      if (start_i) m_ign <= 1;
      if (m_step == W - 1) begin
        m_busy <= 0; m_result <= vin;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [B-1:0] exp_rd(input logic h, input logic l);
    if (h) return B'(m_result >> B);
    if (l) return m_result[B-1:0];
    return '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R4 eoc", 32'(eoc_o), 32'(!m_busy));
      if (m_busy && m_step == 0) check("R2 first trial", 32'(dac_code_o), 32'(m_code));
      else if (m_ign)            check("R10 ignored start", 32'(dac_code_o), 32'(m_code));
      else                       check("R3 trial code", 32'(dac_code_o), 32'(m_code));
      check("R6 strobe", 32'(ser_vld_o), 32'(m_vld));
      if (m_vld) check("R6 serial bit", 32'(ser_bit_o), 32'(m_ser));
      if (m_busy)        check("R11 held read", 32'(rd_data_o), 32'(exp_rd(hi_sel_i, lo_sel_i)));
      else if (hi_sel_i) check("R7 high byte", 32'(rd_data_o), 32'(exp_rd(1, 0)));
      else if (lo_sel_i) check("R8 low byte", 32'(rd_data_o), 32'(exp_rd(0, 1)));
      else               check("R9 no select", 32'(rd_data_o), 32'h0);
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic convert(input logic [W-1:0] v, input int stray_at);
    vin = v;
    start_i = 1'b1; tick(); start_i = 1'b0;
    for (int k = 0; k < W + 1; k++) begin
      hi_sel_i = k[0]; lo_sel_i = k[1];
      start_i = (k == stray_at);
      tick();
    end
    start_i = 1'b0;
    hi_sel_i = 1'b1; lo_sel_i = 1'b0; #1;
    check("R5 result high", 32'(rd_data_o), 32'(B'(v >> B)));
    hi_sel_i = 1'b0; lo_sel_i = 1'b1; #1;
    check("R5 result low", 32'(rd_data_o), 32'(v[B-1:0]));
    hi_sel_i = 1'b1; #1;
    check("R7 both selects", 32'(rd_data_o), 32'(B'(v >> B)));
    hi_sel_i = 1'b0; lo_sel_i = 1'b0;
    tick();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    check("R1 eoc", 32'(eoc_o), 32'h1);
    check("R1 dac", 32'(dac_code_o), 32'h0);
    check("R1 strobe", 32'(ser_vld_o), 32'h0);
    hi_sel_i = 1'b1; #1; check("R1 read high", 32'(rd_data_o), 32'h0);
    hi_sel_i = 1'b0; lo_sel_i = 1'b1; #1; check("R1 read low", 32'(rd_data_o), 32'h0);
    lo_sel_i = 1'b0;
    rst_n = 1'b1;
    tick();
    convert(12'h000, -1);
    convert(12'hFFF, -1);
    convert(12'h800, -1);
    convert(12'h7FF, 4);
    convert(12'hA5C, 0);
    convert(12'h001, W - 2);
    for (int i = 0; i < 20; i++) convert(W'(i * 1237 + 89), (i % 3 == 0) ? i % W : -1);
    repeat (2) tick();
    finish_run();
  end
endmodule